// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This block carries out the four partial-word instructions of a classic 32-bit load/store architecture: load-left, load-right, store-left and store-right. Each works on a byte address that need not be aligned. The block talks to a 32-bit word-wide memory through a plain request/acknowledge port. Every access it makes uses the command address with its two lowest bits forced to zero. Those two bits pick one of four byte-lane merge cases. The left and right forms are mirror images of each other.

A load reads the aligned word once. It then combines shifted memory bytes with the current contents of the destination register and returns the combined word. A store is a read-modify-write: the block reads the aligned word, replaces the selected lanes with bytes taken from the register value, and writes the result back to the same aligned address. A one-cycle done pulse marks the end of every command. For loads it also carries a register write strobe. That strobe stays low when the destination is register 0, although the read still takes place.

Top module: `pword_unit`

## Requirements
- R1: A command is taken only on a clock edge where `cmd_ready` is high; `cmd_ready` is high only while the unit is idle, and command inputs presented while it is busy have no effect on the access sequence or on the result.
- R2: Every memory request, read or write, carries the command address with bits [1:0] cleared.
- R3: Load-left (`cmd_op` = 2'b00) with offset k = addr[1:0] returns (reg & M) | (mem << S), where M is 00FFFFFF, 0000FFFF, 000000FF, 00000000 and S is 24, 16, 8, 0 for k = 0, 1, 2, 3.
- R4: Load-right (`cmd_op` = 2'b01) returns (reg & M) | (mem >> S), where M is 00000000, FF000000, FFFF0000, FFFFFF00 and S is 0, 8, 16, 24 for k = 0..3.
- R5: Store-left (`cmd_op` = 2'b10) writes (reg >> S) | (mem & M), where S is 24, 16, 8, 0 and M is FFFFFF00, FFFF0000, FF000000, 00000000 for k = 0..3.
- R6: Store-right (`cmd_op` = 2'b11) writes (reg << S) | (mem & M), where S is 0, 8, 16, 24 and M is 00000000, 000000FF, 0000FFFF, 00FFFFFF for k = 0..3.
- R7: A store issues exactly one read and then exactly one write, both to the same aligned address. A load issues exactly one read and never a write.
- R8: A memory request stays asserted, with address, write flag and write data unchanged, until the cycle in which `mem_ack` is seen.
- R9: `done` is high for exactly one cycle per command. `res_data` holds the merged word while `done` is high. `res_wr` is high only with `done`, only for loads, and only when `cmd_dest` is not zero. A load to register 0 still performs its read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| cmd_addr | input | ADDR_W | Byte address, may be unaligned |
| cmd_regv | input | 32 | Current register value (load merge base, store source) |
| cmd_dest | input | 5 | Destination register index for loads |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Aligned word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| res_wr | output | 1 | Register write strobe for loads |
| res_data | output | 32 | Merged word |

## Verification
The bench runs all four byte offsets of every opcode with data patterns whose lanes are all distinct. A design that swapped a left form for a right one, or that was off by one lane in its mask or shift, would therefore return a visibly wrong byte. Acknowledges come after varying wait times, so a design that dropped or changed a request before its acknowledge would break the per-cycle comparison against the reference model. A conflicting command is held on the inputs for the whole of a busy store; a design that re-latched its inputs would read or write the wrong address or merge the wrong data. A load to register 0 confirms that the read is still counted while the write strobe stays low.

// File: rtl/pword_pkg.sv
package pword_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTES    = WORD_W / 8;
    localparam int OFF_W    = $clog2(BYTES);
    localparam int REGIDX_W = 5;

    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'b00,
        OP_LOAD_RIGHT  = 2'b01,
        OP_STORE_LEFT  = 2'b10,
        OP_STORE_RIGHT = 2'b11
    } pw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } pw_state_e;

    typedef struct packed {
        pw_op_e                op;
        logic [OFF_W-1:0]      off;
        logic [WORD_W-1:0]     regv;
        logic [REGIDX_W-1:0]   dest;
    } pw_cmd_t;

    function automatic logic is_store(pw_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/pword_merge.sv
module pword_merge
    import pword_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  pw_op_e             op,
    input  logic [OFF_W-1:0]   off,
    input  logic [W-1:0]       regv,
    input  logic [W-1:0]       memv,
    output logic [W-1:0]       merged
);
    localparam int SH_W = OFF_W + 4;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(BYTES - 1);

    logic [OFF_W-1:0] off_inv;
    logic [SH_W-1:0]  sh_up;   // 8 * offset
    logic [SH_W-1:0]  sh_dn;   // 8 * (BYTES-1-offset)

    always_comb begin
        off_inv = TOP_OFF - off;
        sh_up   = {1'b0, off, 3'b000};
        sh_dn   = {1'b0, off_inv, 3'b000};
        unique case (op)
            OP_LOAD_LEFT:   merged = (regv & (ONES >> (sh_up + SH_W'(8)))) | (memv << sh_dn);
            OP_LOAD_RIGHT:  merged = (regv & ~(ONES >> sh_up)) | (memv >> sh_up);
            OP_STORE_LEFT:  merged = (regv >> sh_dn) | (memv & ~(ONES >> sh_dn));
            OP_STORE_RIGHT: merged = (regv << sh_up) | (memv & ~(ONES << sh_up));
            default:        merged = '0;
        endcase
    end
endmodule

// File: rtl/pword_seq.sv
module pword_seq
    import pword_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  pw_op_e               cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WORD_W-1:0]    cmd_regv,
    input  logic [REGIDX_W-1:0]  cmd_dest,
    output logic                 cmd_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output pw_cmd_t              held,
    output logic [WORD_W-1:0]    mem_word,
    input  logic [WORD_W-1:0]    merged,
    output logic                 done,
    output logic                 res_wr,
    output logic [WORD_W-1:0]    res_data
);
    pw_state_e              state, state_nx;
    logic [ADDR_W-OFF_W-1:0] word_addr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_nx = ST_READ;
            ST_READ:  if (mem_ack)   state_nx = is_store(held.op) ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_ack)   state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            held      <= '0;
            word_addr <= '0;
            mem_word  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cmd_valid) begin
                held.op   <= cmd_op;
                held.off  <= cmd_addr[OFF_W-1:0];
                held.regv <= cmd_regv;
                held.dest <= cmd_dest;
                word_addr <= cmd_addr[ADDR_W-1:OFF_W];
            end
            if (state == ST_READ && mem_ack) begin
                mem_word <= mem_rdata;
            end
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = {word_addr, {OFF_W{1'b0}}};
    assign mem_wdata = merged;
    assign done      = (state == ST_DONE);
    assign res_wr    = done && !is_store(held.op) && (held.dest != '0);
    assign res_data  = merged;

    // R8: request held until acknowledged
    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: aligned address on every request
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: loads never write
    assert_load_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> is_store(held.op));

    // R1: no memory traffic while ready for a new command
    assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!mem_req && !done));

    // R9: write strobe only together with done
    assert_res_wr_done_R9: assert property (@(posedge clk) disable iff (rst)
        res_wr |-> done);

endmodule

// File: rtl/pword_unit.sv
module pword_unit
    import pword_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WORD_W-1:0]    cmd_regv,
    input  logic [REGIDX_W-1:0]  cmd_dest,
    output logic                 cmd_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 res_wr,
    output logic [WORD_W-1:0]    res_data
);
    pw_cmd_t           held;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] merged;

    pword_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (pw_op_e'(cmd_op)),
        .cmd_addr  (cmd_addr),
        .cmd_regv  (cmd_regv),
        .cmd_dest  (cmd_dest),
        .cmd_ready (cmd_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .held      (held),
        .mem_word  (mem_word),
        .merged    (merged),
        .done      (done),
        .res_wr    (res_wr),
        .res_data  (res_data)
    );

    pword_merge #(.W(WORD_W)) u_merge (
        .op     (held.op),
        .off    (held.off),
        .regv   (held.regv),
        .memv   (mem_word),
        .merged (merged)
    );
endmodule

// File: tb/pword_unit_bench.sv
`timescale 1ns/1ps
module pword_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_regv = '0;
    logic [4:0]  cmd_dest = '0;
    logic        cmd_ready, mem_req, mem_we, done, res_wr;
    logic [31:0] mem_addr, mem_wdata, res_data;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cfg_wait = 0;
    int wcnt = 0;
    int rd_n = 0;
    int wr_n = 0;
    logic [31:0] mem [16];

    // reference phase model: 0 idle, 1 read, 2 write, 3 done
    int          m_ph = 0;
    logic        m_store = 1'b0;
    logic [31:0] m_addr = '0;

    always #2.5 clk = ~clk;

    pword_unit u_pword_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_regv(cmd_regv), .cmd_dest(cmd_dest),
        .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .res_wr(res_wr), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_merge(input int op, input int k, input logic [31:0] r, input logic [31:0] m);
        logic [31:0] x;
        x = '0;
        case (op)
            0: case (k) // R3
                0: x = (r & 32'h00FFFFFF) | (m << 24);
                1: x = (r & 32'h0000FFFF) | (m << 16);
                2: x = (r & 32'h000000FF) | (m << 8);
                default: x = m;
            endcase
            1: case (k) // R4
                0: x = m;
                1: x = (r & 32'hFF000000) | (m >> 8);
                2: x = (r & 32'hFFFF0000) | (m >> 16);
                default: x = (r & 32'hFFFFFF00) | (m >> 24);
            endcase
            2: case (k) // R5
                0: x = (r >> 24) | (m & 32'hFFFFFF00);
                1: x = (r >> 16) | (m & 32'hFFFF0000);
                2: x = (r >> 8)  | (m & 32'hFF000000);
                default: x = r;
            endcase
            default: case (k) // R6
                0: x = r;
                1: x = (r << 8)  | (m & 32'h000000FF);
                2: x = (r << 16) | (m & 32'h0000FFFF);
                default: x = (r << 24) | (m & 32'h00FFFFFF);
            endcase
        endcase
        return x;
    endfunction

    // memory responder: ack after cfg_wait idle cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= cfg_wait) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[5:2]];
                wcnt      <= 0;
            end else begin
                mem_ack <= 1'b0;
                wcnt    <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[5:2]] <= mem_wdata;
                wr_n <= wr_n + 1;
            end else begin
                rd_n <= rd_n + 1;
            end
        end
    end

    // reference phase model
    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0;
        end else begin
            case (m_ph)
                0: if (cmd_valid) begin
                    m_ph    <= 1;
                    m_store <= cmd_op[1];
                    m_addr  <= {cmd_addr[31:2], 2'b00};
                end
                1: if (mem_ack) m_ph <= m_store ? 2 : 3;
                2: if (mem_ack) m_ph <= 3;
                default: m_ph <= 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(cmd_ready == (m_ph == 0), "R1 ready vs model", 32'(cmd_ready), 32'(m_ph == 0));
            chk(mem_req == (m_ph == 1 || m_ph == 2), "R8 request vs model", 32'(mem_req), 32'(m_ph == 1 || m_ph == 2));
            chk(mem_we == (m_ph == 2), "R7 write flag vs model", 32'(mem_we), 32'(m_ph == 2));
            chk(done == (m_ph == 3), "R9 done vs model", 32'(done), 32'(m_ph == 3));
            if (mem_req)
                chk(mem_addr == m_addr, "R2 aligned address", mem_addr, m_addr);
        end
    end

    task automatic run_cmd(input int op, input logic [31:0] addr, input logic [31:0] regv,
                           input logic [4:0] dest, input bit hold_busy);
        logic [31:0] old, exp;
        int rd0, wr0, n;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready before command", 32'(cmd_ready), 32'd1);
        old = mem[addr[5:2]];
        rd0 = rd_n;
        wr0 = wr_n;
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_addr  = addr;
        cmd_regv  = regv;
        cmd_dest  = dest;
        @(negedge clk);
        if (hold_busy) begin
            cmd_op   = 2'(op) ^ 2'b10;
            cmd_addr = addr + 32'd4;
            cmd_regv = ~regv;
            cmd_dest = dest ^ 5'd7;
        end else begin
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        exp = ref_merge(op, int'(addr[1:0]), regv, old);
        case (op)
            0: chk(res_data == exp, "R3 load-left result", res_data, exp);
            1: chk(res_data == exp, "R4 load-right result", res_data, exp);
            2: chk(mem[addr[5:2]] == exp, "R5 store-left memory", mem[addr[5:2]], exp);
            default: chk(mem[addr[5:2]] == exp, "R6 store-right memory", mem[addr[5:2]], exp);
        endcase
        chk(res_wr == (op < 2 && dest != 0), "R9 write strobe", 32'(res_wr), 32'(op < 2 && dest != 0));
        chk(rd_n - rd0 == 1, "R7 read count", 32'(rd_n - rd0), 32'd1);
        chk(wr_n - wr0 == (op >= 2 ? 1 : 0), "R7 write count", 32'(wr_n - wr0), 32'(op >= 2 ? 1 : 0));
        if (hold_busy)
            chk(mem[(addr[5:2] + 4'd1)] == 32'hC0DE0000 + 32'(addr[5:2] + 4'd1),
                "R1 busy command ignored", mem[(addr[5:2] + 4'd1)], 32'hC0DE0000 + 32'(addr[5:2] + 4'd1));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h11223344 ^ (32'(i) * 32'h01010101);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R1 reset state",
            {29'd0, cmd_ready, mem_req, done}, 32'd4);
        rst = 1'b0;
        for (int w = 0; w < 3; w++) begin
            cfg_wait = w;
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 4; k++) begin
                    run_cmd(op, 32'h40 + 32'(op * 16) + 32'(k),
                            32'hA1B2C3D4 ^ 32'(w * 32'h10203040), 5'd3, 1'b0);
                end
            end
        end
        // R9: load to register 0 still reads, no strobe
        cfg_wait = 1;
        run_cmd(0, 32'h22, 32'h55667788, 5'd0, 1'b0);
        run_cmd(1, 32'h23, 32'h55667788, 5'd0, 1'b0);
        // R1: conflicting command held while busy; neighbour word must stay untouched
        mem[9] = 32'hC0DE0009;
        run_cmd(3, 32'h21, 32'hDEADBEEF, 5'd2, 1'b1);
        mem[3] = 32'hC0DE0003;
        cfg_wait = 2;
        run_cmd(2, 32'h0A, 32'h0BADF00D, 5'd9, 1'b1);
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule